// File: doc/BRIEF.md
# 66-bit Sync Header Error Injector

This block sits on the transmit side of a 64b/66b coding layer, after the scrambler. For every valid 64-bit payload word it adds the 2-bit sync header and sends out a registered 66-bit block. A per-word flag tells it whether the word is a control block or a data block.

A test can ask for a corrupted header on exactly one block. The request is a level bit, for example from a register or a pin, and it is not tied to the block clock. Each 0-to-1 change of that bit arms one injection, and only if the separate static enable is high. The armed block keeps its payload unchanged, but its header is replaced by an illegal value that depends on the block type. A receiver's lock and error-handling paths can then be exercised one block at a time. A saturating counter, with a synchronous clear, records how many corrupted blocks have left the block.

Top module: `sh_err_injector`

## Requirements
- R1: An uncorrupted output block carries header value 2'b10 for a data word (ctrl flag 0) or 2'b01 for a control word (ctrl flag 1) in bits [1:0], and the payload unchanged in bits [65:2]. Bit 0 is sent first.
- R2: An injected block carries header 2'b11 in place of 2'b10 for data, or 2'b00 in place of 2'b01 for control. Its payload bits [65:2] are unchanged.
- R3: Each 0-to-1 transition of `err_req` produces exactly one corrupted block. Holding `err_req` high produces no further errors.
- R4: Corruption needs `inj_en` high. A request edge detected while `inj_en` is low is discarded and never causes an error later. Dropping `inj_en` also cancels a pending injection.
- R5: An armed injection waits through cycles with `pl_valid` low and is applied to the next valid payload word.
- R6: A request edge that arrives while an injection is pending does not add a second error.
- R7: `blk_valid` and `blk_out` follow `pl_valid` and the payload by one clock. The earliest block that can be corrupted is the one presented on the third rising edge after the edge that first samples `err_req` high.
- R8: `err_count` increases by one for each corrupted block, in the same cycle that block appears, and holds at its maximum value 2**CNT_W-1.
- R9: `cnt_clr` sets `err_count` to zero on the next edge and takes priority over an increment.
- R10: After reset, `blk_valid` is 0, `err_count` is 0 and no injection is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| inj_en | input | 1 | Static enable for error injection |
| err_req | input | 1 | Error request level; each rising edge arms one error |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| pl_valid | input | 1 | Payload word valid |
| pl_ctrl | input | 1 | 1 = control block, 0 = data block |
| pl_data | input | 64 | Scrambled payload word |
| blk_valid | output | 1 | Output block valid |
| blk_out | output | 66 | Header in [1:0], payload in [65:2] |
| err_count | output | CNT_W | Saturating count of corrupted blocks |

## Verification
The output block, its valid bit and the counter all update on the clock edge that samples the payload word. The bench therefore drives inputs on the falling edge and compares all three at the next falling edge, one clock after the word was presented. A request edge passes through two synchronizer stages and an edge-detect register before it arms the pending flag, so it can first affect the block presented on the third edge after the request is sampled. The bench's reference model steps through these same stages once per clock, so each expected header lands in the right cycle. Directed sequences then read `err_count` at the ports to confirm held requests, discarded edges, stacking, clearing and saturation.

// File: rtl/sh_err_injector.sv
module sh_err_injector #(
  parameter int PAYLOAD_W = 64,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inj_en,
  input  logic                 err_req,
  input  logic                 cnt_clr,
  input  logic                 pl_valid,
  input  logic                 pl_ctrl,
  input  logic [PAYLOAD_W-1:0] pl_data,
  output logic                 blk_valid,
  output logic [PAYLOAD_W+1:0] blk_out,
  output logic [CNT_W-1:0]     err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic req_s1, req_s2, req_prev, pending;
  logic req_edge, corrupt;
  logic [1:0] hdr;

  assign req_edge = req_s2 & ~req_prev;
  assign corrupt  = pending & pl_valid & inj_en;
  assign hdr      = corrupt ? {~pl_ctrl, ~pl_ctrl} : {~pl_ctrl, pl_ctrl};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_s1   <= 1'b0;
      req_s2   <= 1'b0;
      req_prev <= 1'b0;
      pending  <= 1'b0;
    end else begin
      req_s1   <= err_req;
      req_s2   <= req_s1;
      req_prev <= req_s2;
      pending  <= inj_en & ((pending & ~pl_valid) | (req_edge & ~pending));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_valid <= 1'b0;
      blk_out   <= '0;
    end else begin
      blk_valid <= pl_valid;
      if (pl_valid) blk_out <= {pl_data, hdr};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              err_count <= '0;
    else if (cnt_clr)                     err_count <= '0;
    else if (corrupt && err_count != CNT_MAX) err_count <= err_count + 1'b1;
  end

  assert_single_err_R3: assert property (@(posedge clk) disable iff (rst)
    corrupt |=> !corrupt);
  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !inj_en |=> !pending);
  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    pl_valid |=> blk_valid);
  assert_idle_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !pl_valid |=> !blk_valid);
  assert_hold_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !corrupt) |=> $stable(err_count));
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> err_count == '0);
  assert_payload_R2: assert property (@(posedge clk) disable iff (rst)
    pl_valid |=> blk_out[PAYLOAD_W+1:2] == $past(pl_data));
endmodule

// File: tb/sim_sh_err_injector.sv
module sim_sh_err_injector;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, inj_en, err_req, cnt_clr, pl_valid, pl_ctrl;
  logic [63:0] pl_data;
  logic blk_valid;
  logic [65:0] blk_out;
  logic [CW-1:0] err_count;

  int checks = 0, errors = 0, cyc = 0;
  logic m_s1, m_s2, m_prev, m_pend;
  int m_cnt;

  always #4 clk = ~clk;

  sh_err_injector #(.PAYLOAD_W(64), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .inj_en(inj_en), .err_req(err_req), .cnt_clr(cnt_clr),
    .pl_valid(pl_valid), .pl_ctrl(pl_ctrl), .pl_data(pl_data),
    .blk_valid(blk_valid), .blk_out(blk_out), .err_count(err_count));

  task automatic chk(input logic ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hdr(input logic ctrl, input logic bad);
    if (bad) return ctrl ? 2'b00 : 2'b11;
    return ctrl ? 2'b01 : 2'b10;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_cnt = 0;
  endtask

  task automatic step(input logic v, input logic c, input logic [63:0] d,
                      input logic en, input logic rq, input logic clr);
    logic edg, bad;
    logic [65:0] eblk;
    pl_valid = v; pl_ctrl = c; pl_data = d; inj_en = en; err_req = rq; cnt_clr = clr;
    edg  = m_s2 & ~m_prev;
    bad  = m_pend & v & en;
    eblk = {d, exp_hdr(c, bad)};
    m_pend = en & ((m_pend & ~v) | (edg & ~m_pend));
    m_prev = m_s2; m_s2 = m_s1; m_s1 = rq;
    if (clr) m_cnt = 0;
    else if (bad && m_cnt < MAXC) m_cnt++;
    @(negedge clk);
    chk(blk_valid == v, "R7 blk_valid", 66'(blk_valid), 66'(v));
    if (v) begin
      chk(blk_out[65:2] == d, "R2 payload", blk_out, eblk);
      chk(blk_out[1:0] == eblk[1:0], bad ? "R2 injected header" : "R1 normal header",
          66'(blk_out[1:0]), 66'(eblk[1:0]));
    end
    chk(err_count == CW'(m_cnt), "R8 err_count", 66'(err_count), 66'(m_cnt));
  endtask

  task automatic idle(input int n, input logic en, input logic rq);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 64'h0, en, rq, 1'b0);
  endtask

  task automatic run(input int n, input logic en, input logic rq);
    for (int i = 0; i < n; i++)
      step(1'b1, 1'($urandom), {$urandom, $urandom}, en, rq, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    rst = 1; inj_en = 0; err_req = 0; cnt_clr = 0; pl_valid = 0; pl_ctrl = 0; pl_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    chk(blk_valid == 1'b0, "R10 reset blk_valid", 66'(blk_valid), 66'd0);
    chk(err_count == '0, "R10 reset err_count", 66'(err_count), 66'd0);

    // R1 plain traffic, no request
    run(10, 1'b1, 1'b0);
    chk(err_count == '0, "R1 no spurious errors", 66'(err_count), 66'd0);

    // R3 / R7 held request gives one error
    base = m_cnt;
    run(20, 1'b1, 1'b1);
    chk(int'(err_count) == base + 1, "R3 held request one error", 66'(err_count), 66'(base + 1));
    run(5, 1'b1, 1'b0);

    // R4 edge while disabled is discarded
    base = int'(err_count);
    run(6, 1'b0, 1'b1);
    run(10, 1'b1, 1'b1);
    chk(int'(err_count) == base, "R4 disabled edge discarded", 66'(err_count), 66'(base));
    run(4, 1'b1, 1'b0);

    // R5 pending survives idle cycles
    base = int'(err_count);
    idle(2, 1'b1, 1'b1);
    idle(10, 1'b1, 1'b0);
    chk(int'(err_count) == base, "R5 idle does not consume", 66'(err_count), 66'(base));
    run(3, 1'b1, 1'b0);
    chk(int'(err_count) == base + 1, "R5 applied on next valid", 66'(err_count), 66'(base + 1));

    // R6 second edge while pending does not stack
    base = int'(err_count);
    idle(2, 1'b1, 1'b1);
    idle(2, 1'b1, 1'b0);
    idle(2, 1'b1, 1'b1);
    idle(6, 1'b1, 1'b0);
    run(10, 1'b1, 1'b0);
    chk(int'(err_count) == base + 1, "R6 no stacking", 66'(err_count), 66'(base + 1));

    // R9 clear
    step(1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 1'b1);
    chk(err_count == '0, "R9 clear", 66'(err_count), 66'd0);

    // R8 saturation
    for (int k = 0; k < MAXC + 4; k++) begin
      run(2, 1'b1, 1'b1);
      run(4, 1'b1, 1'b0);
    end
    chk(int'(err_count) == MAXC, "R8 saturates", 66'(err_count), 66'(MAXC));
    step(1'b1, 1'b1, 64'h0, 1'b1, 1'b0, 1'b1);

    // random mix
    begin
      logic rq = 0, en = 1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 7) == 0) rq = ~rq;
        if ($urandom_range(0, 31) == 0) en = ~en;
        step(1'($urandom_range(0, 3) != 0), 1'($urandom), {$urandom, $urandom},
             en, rq, 1'($urandom_range(0, 199) == 0));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule